// File: doc/BRIEF.md
# Interrupt Event Combiner and Level Router

This block gathers 128 peripheral event lines and presents twelve interrupt requests to a core controller, one per core priority level from 4 up to 15. Each event is caught as a sticky flag on its rising edge. Software clears a flag by writing a one to its bit.

The events fall into four groups of 32. Each group has a combiner that ORs those flags of the group that are not masked. A combiner drives whichever core level its route register names.

Twelve selector registers, one per core level, can pick out a single event and tie it straight to that level. Such an event then no longer counts in its group's combiner. Software configures the block through a simple word-addressed write/read port. After reset every event goes through its combiner, and combiners 0 to 3 drive levels 12 to 15.

Top module: `evt_router`

## Requirements
- R1: A rising edge on `evt_i[e]` sets flag `e` on the next clock, whether or not the event is masked. A level held high sets the flag only once, so a flag cleared while its input stays high remains clear.
- R2: Flag words are at addresses 0 to 3, and word `w` holds events `32w` to `32w+31` with bit `b` being event `32w+b`. Writing a word clears the flags whose data bits are one and leaves the others alone. A rising edge in the same cycle as a clear of that flag leaves the flag set.
- R3: Combiner `n` is active when any event in `32n` to `32n+31` has its flag set and its mask bit zero. Mask words are at addresses 4 to 7, with the same bit layout as the flag words. A mask bit of one keeps its event out of the combiner.
- R4: The selector for level `L` is at address `8+(L-4)` and holds a 7-bit event number in bits 6:0. A value `v` from 4 to 127 drives `irq_o[L-4]` from flag `v`. Output bit 0 is level 4 and bit 11 is level 15. The mask does not act on a direct route.
- R5: Selector values 0 to 3 route no event, so all events stay with their combiners.
- R6: An event named by any selector with a value from 4 to 127 does not contribute to its combiner.
- R7: The route register for combiner `n` is at address `20+n` and holds a level in bits 3:0. A value from 4 to 15 drives `irq_o[value-4]`, and any other value leaves the combiner unconnected.
- R8: Where a combiner and a selector, or several of either, target the same level, that output is the OR of all of them.
- R9: After reset, flags, masks and selectors are zero, route registers hold 12, 13, 14 and 15, and `irq_o` is zero.
- R10: Every register reads back on `rdata_o` in the same cycle its address is presented. Unused upper bits and addresses 24 to 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 128 | Peripheral event lines |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 12 | Requests to core levels 4 (bit 0) to 15 (bit 11) |

## Verification
Two things can happen to one flag in the same cycle: a fresh rising edge and a software clear. The bench forces this by raising an event at the very clock edge that carries a clear write for the same bit, and it then expects the flag still set. A random phase drives event toggles and register writes together, so clears, mask changes and selector changes meet new edges as well. A behavioural reference model predicts `irq_o` and the read data, and every cycle is compared against it.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  localparam int EVT_N    = 128;
  localparam int GRP_W    = 32;
  localparam int LVL_N    = 12;
  localparam int LVL_BASE = 4;
  localparam int SEL_W    = 7;
  localparam int LVL_W    = 4;
  localparam int AW       = 5;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int N = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] prev_q;

  assign rise_o = evt_i & ~prev_q;

  // a new edge outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_o <= '0;
    end else begin
      prev_q <= evt_i;
      flag_o <= (flag_o & ~clr_i) | rise_o;
    end
  end
endmodule

// File: rtl/evt_combiner.sv
module evt_combiner #(
  parameter int GRP_N = 4,
  parameter int GRP_W = 32,
  localparam int N = GRP_N * GRP_W
) (
  input  logic [N-1:0]     flag_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     excl_i,
  output logic [GRP_N-1:0] comb_o
);
  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign comb_o[g] = |(flag_i[g*GRP_W +: GRP_W] & ~mask_i[g*GRP_W +: GRP_W]
                         & ~excl_i[g*GRP_W +: GRP_W]);
  end
endmodule

// File: rtl/lvl_router.sv
module lvl_router #(
  parameter int EVT_N    = 128,
  parameter int GRP_N    = 4,
  parameter int LVL_N    = 12,
  parameter int LVL_BASE = 4,
  parameter int SEL_W    = 7,
  parameter int LVL_W    = 4
) (
  input  logic [EVT_N-1:0]            flag_i,
  input  logic [LVL_N-1:0][SEL_W-1:0] sel_i,
  input  logic [GRP_N-1:0][LVL_W-1:0] route_i,
  input  logic [GRP_N-1:0]            comb_i,
  output logic [EVT_N-1:0]            excl_o,
  output logic [LVL_N-1:0]            irq_o
);
  always_comb begin
    excl_o = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (int'(sel_i[l]) >= LVL_BASE && int'(sel_i[l]) < EVT_N) excl_o[int'(sel_i[l])] = 1'b1;
    end
  end

  always_comb begin
    irq_o = '0;
    for (int l = 0; l < LVL_N; l++) begin
      if (int'(sel_i[l]) >= LVL_BASE && int'(sel_i[l]) < EVT_N)
        irq_o[l] = irq_o[l] | flag_i[int'(sel_i[l])];
    end
    for (int n = 0; n < GRP_N; n++) begin
      if (int'(route_i[n]) >= LVL_BASE && int'(route_i[n]) < LVL_BASE + LVL_N)
        irq_o[int'(route_i[n]) - LVL_BASE] = irq_o[int'(route_i[n]) - LVL_BASE] | comb_i[n];
    end
  end
endmodule

// File: rtl/evt_router.sv
module evt_router
  import evt_router_pkg::*;
#(
  parameter int NUM_EVT  = EVT_N,
  parameter int GRP_SZ   = GRP_W,
  parameter int NUM_LVL  = LVL_N,
  parameter int BASE_LVL = LVL_BASE,
  localparam int NUM_GRP = NUM_EVT / GRP_SZ,
  localparam int DW      = GRP_SZ,
  localparam int A_FLAG  = 0,
  localparam int A_MASK  = NUM_GRP,
  localparam int A_SEL   = 2 * NUM_GRP,
  localparam int A_ROUTE = 2 * NUM_GRP + NUM_LVL
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NUM_LVL-1:0] irq_o
);
  logic [NUM_EVT-1:0]                rise, flag_q, clr, mask_q, excl;
  logic [NUM_GRP-1:0]                comb;
  logic [NUM_LVL-1:0][SEL_W-1:0]     sel_q;
  logic [NUM_GRP-1:0][LVL_W-1:0]     route_q;

  always_comb begin
    clr = '0;
    for (int w = 0; w < NUM_GRP; w++)
      if (we_i && int'(addr_i) == A_FLAG + w) clr[w*DW +: DW] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      sel_q  <= '0;
      for (int n = 0; n < NUM_GRP; n++) route_q[n] <= LVL_W'(BASE_LVL + NUM_LVL - NUM_GRP + n);
    end else if (we_i) begin
      for (int w = 0; w < NUM_GRP; w++)
        if (int'(addr_i) == A_MASK + w) mask_q[w*DW +: DW] <= wdata_i;
      for (int l = 0; l < NUM_LVL; l++)
        if (int'(addr_i) == A_SEL + l) sel_q[l] <= wdata_i[SEL_W-1:0];
      for (int n = 0; n < NUM_GRP; n++)
        if (int'(addr_i) == A_ROUTE + n) route_q[n] <= wdata_i[LVL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_GRP; w++) begin
      if (int'(addr_i) == A_FLAG + w) rdata_o = flag_q[w*DW +: DW];
      if (int'(addr_i) == A_MASK + w) rdata_o = mask_q[w*DW +: DW];
      if (int'(addr_i) == A_ROUTE + w) rdata_o = DW'(route_q[w]);
    end
    for (int l = 0; l < NUM_LVL; l++)
      if (int'(addr_i) == A_SEL + l) rdata_o = DW'(sel_q[l]);
  end

  evt_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk_i (clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_i(clr),
    .rise_o(rise), .flag_o(flag_q)
  );

  evt_combiner #(.GRP_N(NUM_GRP), .GRP_W(GRP_SZ)) u_comb (
    .flag_i(flag_q), .mask_i(mask_q), .excl_i(excl), .comb_o(comb)
  );

  lvl_router #(
    .EVT_N(NUM_EVT), .GRP_N(NUM_GRP), .LVL_N(NUM_LVL), .LVL_BASE(BASE_LVL),
    .SEL_W(SEL_W), .LVL_W(LVL_W)
  ) u_route (
    .flag_i(flag_q), .sel_i(sel_q), .route_i(route_q), .comb_i(comb),
    .excl_o(excl), .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk #(
  parameter int NUM_EVT  = 128,
  parameter int NUM_GRP  = 4,
  parameter int GRP_SZ   = 32,
  parameter int NUM_LVL  = 12,
  parameter int BASE_LVL = 4,
  parameter int SEL_W    = 7
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_EVT-1:0]            rise,
  input logic [NUM_EVT-1:0]            flag_q,
  input logic [NUM_EVT-1:0]            clr,
  input logic [NUM_EVT-1:0]            mask_q,
  input logic [NUM_GRP-1:0]            comb,
  input logic [NUM_LVL-1:0][SEL_W-1:0] sel_q,
  input logic [NUM_LVL-1:0]            irq_o
);
  p_flag_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((flag_q & $past(rise)) == $past(rise)));

  p_clear_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(flag_q) & ~flag_q) != '0) |-> ($past(clr) != '0));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q == '0) |-> (irq_o == '0));

  for (genvar n = 0; n < NUM_GRP; n++) begin : g_c
    p_comb_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      comb[n] |-> |(flag_q[n*GRP_SZ +: GRP_SZ] & ~mask_q[n*GRP_SZ +: GRP_SZ]));
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_d
    p_direct_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sel_q[l]) >= BASE_LVL && flag_q[sel_q[l]]) |-> irq_o[l]);
  end
endmodule

bind evt_router evt_router_chk #(
  .NUM_EVT(NUM_EVT), .NUM_GRP(NUM_GRP), .GRP_SZ(GRP_SZ), .NUM_LVL(NUM_LVL),
  .BASE_LVL(BASE_LVL), .SEL_W(evt_router_pkg::SEL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rise(rise), .flag_q(flag_q), .clr(clr),
  .mask_q(mask_q), .comb(comb), .sel_q(sel_q), .irq_o(irq_o)
);

// File: tb/tb_evt_router.sv
`timescale 1ns/1ps
module tb_evt_router;
  logic         clk = 0, rst_n = 0;
  logic [127:0] evt = '0;
  logic         we = 0;
  logic [4:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [11:0]  irq;
  int checks = 0, errors = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  evt_router dut (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .we_i(we), .addr_i(addr),
                  .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // behavioural reference
  bit m_flag[128], m_prev[128], m_mask[128];
  int m_sel[12], m_route[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[e]) begin m_flag[e] = 0; m_prev[e] = 0; m_mask[e] = 0; end
      foreach (m_sel[l]) m_sel[l] = 0;
      foreach (m_route[n]) m_route[n] = 12 + n;
    end else begin
      for (int e = 0; e < 128; e++) begin
        bit up, cl;
        up = evt[e] && !m_prev[e];
        cl = we && addr == 5'(e / 32) && wdata[e % 32];
        if (up) m_flag[e] = 1; else if (cl) m_flag[e] = 0;
        m_prev[e] = evt[e];
      end
      if (we) begin
        if (addr >= 4 && addr < 8) for (int b = 0; b < 32; b++) m_mask[(addr - 4) * 32 + b] = wdata[b];
        else if (addr >= 8 && addr < 20) m_sel[addr - 8] = int'(wdata[6:0]);
        else if (addr >= 20 && addr < 24) m_route[addr - 20] = int'(wdata[3:0]);
      end
    end
  end

  function automatic logic [11:0] exp_irq();
    bit direct[128];
    bit grp[4];
    logic [11:0] r = '0;
    foreach (direct[e]) direct[e] = 0;
    foreach (grp[n]) grp[n] = 0;
    for (int l = 0; l < 12; l++)
      if (m_sel[l] >= 4) begin direct[m_sel[l]] = 1; if (m_flag[m_sel[l]]) r[l] = 1; end
    for (int e = 0; e < 128; e++)
      if (m_flag[e] && !m_mask[e] && !direct[e]) grp[e / 32] = 1;
    for (int n = 0; n < 4; n++)
      if (grp[n] && m_route[n] >= 4 && m_route[n] <= 15) r[m_route[n] - 4] = 1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    logic [31:0] v = '0;
    if (a < 4) for (int b = 0; b < 32; b++) v[b] = m_flag[a * 32 + b];
    else if (a < 8) for (int b = 0; b < 32; b++) v[b] = m_mask[(a - 4) * 32 + b];
    else if (a < 20) v = 32'(m_sel[a - 8]);
    else if (a < 24) v = 32'(m_route[a - 20]);
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison of the outputs (R8 composition)
  always @(negedge clk) if (live) begin
    #1 chk(irq === exp_irq(), "R8 irq vs model", 32'(irq), 32'(exp_irq()));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); we = 1; addr = 5'(a); wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk); addr = 5'(a);
    #2 chk(rdata === exp_rd(a), tag, rdata, exp_rd(a));
  endtask

  task automatic pulse(int e);
    @(negedge clk); evt[e] = 1;
    @(negedge clk); evt[e] = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    // R9 reset state
    @(negedge clk); #2 chk(irq === 12'h0, "R9 irq after reset", 32'(irq), 0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); addr = 5'(20 + n);
      #2 chk(rdata === 32'(12 + n), "R9 route reset", rdata, 32'(12 + n));
    end
    rd(4, "R9 mask reset"); rd(8, "R9 sel reset");
    // R1 edge sets flag, group 1 drives level 13 -> bit 9
    pulse(40);
    #2 chk(irq === 12'h200, "R1 R3 event 40 to level 13", 32'(irq), 32'h200);
    @(negedge clk); addr = 5'd1;
    #2 chk(rdata === 32'h100, "R1 flag word 1", rdata, 32'h100);
    // R2 zero write leaves flags
    wr(1, 32'h0); rd(1, "R2 zero clear no effect");
    wr(1, 32'h100); rd(1, "R2 ones clear");
    // R1 held high sets once
    @(negedge clk); evt[41] = 1;
    repeat (2) @(negedge clk);
    wr(1, 32'h200); rd(1, "R1 held level no re-set");
    @(negedge clk); evt[41] = 0;
    // R3 mask blocks combiner, flag still set
    wr(5, 32'h100); pulse(40);
    #2 chk(irq === 12'h0, "R3 masked event quiet", 32'(irq), 0);
    rd(1, "R1 masked event still flags");
    wr(5, 32'h0);
    #2 chk(irq[9] === 1'b1, "R3 unmask exposes flag", 32'(irq), 32'h200);
    wr(1, 32'hffff_ffff);
    // R2 edge and clear same cycle
    pulse(70);
    @(negedge clk); evt[70] = 1; we = 1; addr = 5'd2; wdata = 32'h40;
    @(negedge clk); we = 0; evt[70] = 0;
    rd(2, "R2 edge beats clear");
    @(negedge clk); addr = 5'd2;
    #2 chk(rdata[6] === 1'b1, "R2 edge beats clear bit", rdata, 32'h40);
    wr(2, 32'hffff_ffff);
    // R4 R6 direct route of event 32 to level 8 (bit 4)
    wr(12, 32'd32); pulse(32);
    #2 chk(irq === 12'h010, "R4 R6 direct route only", 32'(irq), 32'h010);
    wr(5, 32'h1);
    #2 chk(irq === 12'h010, "R4 mask ignored on direct", 32'(irq), 32'h010);
    wr(5, 32'h0);
    // R5 selector value 2 returns event to combiner
    wr(12, 32'd2);
    #2 chk(irq === 12'h200, "R5 low selector value", 32'(irq), 32'h200);
    wr(1, 32'hffff_ffff);
    // R7 reroute combiner 0 to level 5, then disconnect
    wr(20, 32'd5); pulse(5);
    #2 chk(irq === 12'h002, "R7 combiner 0 at level 5", 32'(irq), 32'h002);
    wr(20, 32'd0);
    #2 chk(irq === 12'h0, "R7 route 0 disconnects", 32'(irq), 0);
    wr(20, 32'd3);
    #2 chk(irq === 12'h0, "R7 route 3 disconnects", 32'(irq), 0);
    wr(0, 32'hffff_ffff); wr(20, 32'd12);
    // R8 combiner 2 and direct event 32 share level 8
    wr(22, 32'd8); wr(12, 32'd32);
    pulse(70);
    #2 chk(irq === 12'h010, "R8 combiner onto level 8", 32'(irq), 32'h010);
    pulse(32);
    #2 chk(irq === 12'h010, "R8 both sources", 32'(irq), 32'h010);
    wr(2, 32'hffff_ffff);
    #2 chk(irq === 12'h010, "R8 direct alone holds level", 32'(irq), 32'h010);
    // R10 readback and unmapped addresses
    rd(12, "R10 selector readback"); rd(22, "R10 route readback");
    wr(19, 32'hffff_ff7f);
    @(negedge clk); addr = 5'd19;
    #2 chk(rdata === 32'h7f, "R10 selector width", rdata, 32'h7f);
    @(negedge clk); addr = 5'd30;
    #2 chk(rdata === 32'h0, "R10 unmapped read", rdata, 0);
    wr(19, 0);
    // random mix of edges, clears and configuration
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) evt[$urandom_range(127)] ^= 1'b1;
      we = ($urandom_range(3) == 0);
      addr = 5'($urandom_range(23));
      wdata = $urandom;
      if (addr >= 8 && addr < 20) wdata = 32'($urandom_range(0, 60) == 0 ? $urandom_range(3) : $urandom_range(127));
      if (addr >= 20) wdata = 32'($urandom_range(17));
      if (addr < 4 && $urandom_range(1)) wdata = 0;
      if (!we) #2 chk(rdata === exp_rd(int'(addr)), "R10 random read", rdata, exp_rd(int'(addr)));
    end
    @(negedge clk); we = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule